// File: doc/BRIEF.md
# Fractional-N Synthesizer Divider Calculator

This block converts a requested output frequency and a reference crystal frequency, both given in hertz as unsigned integers, into the three numbers a two-stage clock synthesizer needs. These are an even integer output divider, the integer part of the feedback multiplier, and the feedback fraction numerator. The fraction denominator is fixed at 2^20-1. The same output divider value is also presented as the phase-offset word. Loaded into one output's phase register, it places that output 90 degrees from its twin.

A caller presents both frequencies with a one-cycle start strobe and waits for a one-cycle done strobe. The arithmetic is exact integer arithmetic. It uses one shared multicycle restoring divider, which runs up to three divisions per request: the ceiling divide, the feedback ratio, and the fraction numerator. When a request cannot produce a legal feedback ratio, an error flag accompanies done and the previous good results stay on the outputs.

Top module: `fracn_div_calc`

## Requirements
- R1: When fout × 126 is at most 900,000,000, the output divider is 126.
- R2: When fout × 126 exceeds 900,000,000, the output divider is floor(900,000,000 / fout) with its least significant bit cleared, so it is always even.
- R3: The multiplier integer output is floor(fvco / fxtal), where fvco = fout × (output divider).
- R4: The fraction numerator is floor((fvco mod fxtal) × 1,048,575 / fxtal), and it is therefore always below 1,048,575.
- R5: The phase-offset word always equals the output divider value.
- R6: The feedback ratio fvco / fxtal must lie in [15, 90] inclusive. A ratio of exactly 90 is accepted only with a zero remainder. Outside that range, done comes with err = 1 and the divider, multiplier, numerator and phase outputs keep their previous values. A zero fxtal also fails this way.
- R7: A request with fout = 0 completes with err = 1 on the cycle after start, and all result outputs unchanged.
- R8: Every accepted start produces exactly one done pulse, one cycle wide. err is valid with it and holds its value until the next done. A successful request sets err = 0.
- R9: A start strobe that arrives while a request is in progress is ignored. The running request finishes with its own inputs, and no further done follows.
- R10: After reset, done, err and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe, accepted only when idle |
| fout | input | 32 | Requested output frequency in Hz |
| fxtal | input | 32 | Reference crystal frequency in Hz |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Request rejected; valid with done, held until the next done |
| out_div | output | 7 | Even output divider |
| mult_int | output | 7 | Integer part of the feedback multiplier |
| frac_num | output | 20 | Feedback fraction numerator over 1,048,575 |
| phase_word | output | 7 | Phase-offset word for the quadrature output |

## Verification
The bench builds the block with its default parameters: 32-bit frequencies, default divider 126, a 900 MHz ceiling, denominator 1,048,575 and ratio band 15 to 90. With these values the full 52-step division runs for each stage. The ceiling edge can be probed at 7,142,857 Hz versus 7,142,858 Hz, where the quotient 125 must drop to 124. Crystal values can also be chosen that put the ratio at exactly 15 and exactly 90, and just outside each limit. Zero output and zero crystal frequencies, and a request far above the ceiling whose divider collapses to zero, are driven to confirm the hold-on-error behaviour.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_CHK  = 3'd1,
      ST_WDIV = 3'd2,
      ST_VCO  = 3'd3,
      ST_WRAT = 3'd4,
      ST_FRAC = 3'd5,
      ST_WNUM = 3'd6
   } calc_state_e;

endpackage

// File: rtl/fdc_seq_div.sv
module fdc_seq_div #(
   parameter int DVD_W = 52,
   parameter int DSR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [DVD_W-1:0] dividend,
   input  logic [DSR_W-1:0] divisor,
   output logic             valid,
   output logic [DVD_W-1:0] quotient,
   output logic [DSR_W-1:0] remainder
);

   localparam int CNT_W = $clog2(DVD_W + 1);

   logic [DVD_W-1:0] quo_q;
   logic [DSR_W-1:0] rem_q;
   logic [DSR_W-1:0] dsr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             valid_q;
   logic [DSR_W:0]   trial;
   logic             fits;

   assign trial = {rem_q, quo_q[DVD_W-1]};
   assign fits  = trial >= {1'b0, dsr_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q   <= '0;
         rem_q   <= '0;
         dsr_q   <= '0;
         cnt_q   <= '0;
         run_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (go) begin
            quo_q <= dividend;
            rem_q <= '0;
            dsr_q <= divisor;
            cnt_q <= CNT_W'(DVD_W);
            run_q <= 1'b1;
         end else if (run_q) begin
            if (fits) begin
               rem_q <= DSR_W'(trial - {1'b0, dsr_q});
               quo_q <= {quo_q[DVD_W-2:0], 1'b1};
            end else begin
               rem_q <= trial[DSR_W-1:0];
               quo_q <= {quo_q[DVD_W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
               run_q   <= 1'b0;
               valid_q <= 1'b1;
            end
         end
      end
   end

   assign valid     = valid_q;
   assign quotient  = quo_q;
   assign remainder = rem_q;

   AST_REM_LT_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && (dsr_q != '0)) |-> (rem_q < dsr_q)); // R4

   AST_VALID_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> !run_q); // R8

endmodule

// File: rtl/fdc_vco_ceiling.sv
module fdc_vco_ceiling #(
   parameter int FREQ_W      = 32,
   parameter int OD_W        = 7,
   parameter int DEFAULT_DIV = 126,
   parameter int VCO_MAX     = 900_000_000
) (
   input  logic [FREQ_W-1:0] fout,
   output logic              over
);

   localparam int PW = FREQ_W + OD_W;

   logic [PW-1:0] prod;

   assign prod = PW'(fout) * PW'(DEFAULT_DIV);
   assign over = prod > PW'(VCO_MAX);

endmodule

// File: rtl/fdc_ratio_guard.sv
module fdc_ratio_guard #(
   parameter int FREQ_W    = 32,
   parameter int RATIO_MIN = 15,
   parameter int RATIO_MAX = 90
) (
   input  logic [FREQ_W-1:0] quo,
   input  logic              quo_hi_nz,
   input  logic              rem_nz,
   output logic              in_range
);

   logic above_min;
   logic below_max;

   assign above_min = quo >= FREQ_W'(RATIO_MIN);
   assign below_max = (quo < FREQ_W'(RATIO_MAX)) ||
                      ((quo == FREQ_W'(RATIO_MAX)) && !rem_nz);
   assign in_range  = !quo_hi_nz && above_min && below_max;

endmodule

// File: rtl/fracn_div_calc.sv
module fracn_div_calc
   import fdc_pkg::*;
#(
   parameter int FREQ_W      = 32,
   parameter int DEFAULT_DIV = 126,
   parameter int VCO_MAX     = 900_000_000,
   parameter int FRAC_DEN    = 1_048_575,
   parameter int RATIO_MIN   = 15,
   parameter int RATIO_MAX   = 90,
   parameter int OD_W        = $clog2(DEFAULT_DIV + 1),
   parameter int MULT_W      = $clog2(RATIO_MAX + 1),
   parameter int FRAC_W      = $clog2(FRAC_DEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] fout,
   input  logic [FREQ_W-1:0] fxtal,
   output logic              done,
   output logic              err,
   output logic [OD_W-1:0]   out_div,
   output logic [MULT_W-1:0] mult_int,
   output logic [FRAC_W-1:0] frac_num,
   output logic [OD_W-1:0]   phase_word
);

   localparam int DVD_W = FREQ_W + FRAC_W;

   // elaboration-time parameter checks
   if (DEFAULT_DIV % 2 != 0) begin : g_bad_default
      $error("DEFAULT_DIV must be even");
   end
   if (RATIO_MIN > RATIO_MAX || RATIO_MIN < 1) begin : g_bad_band
      $error("ratio band is empty or starts at zero");
   end
   if (FRAC_DEN < 2) begin : g_bad_den
      $error("FRAC_DEN must be at least 2");
   end
   if (DVD_W < FREQ_W + OD_W || FRAC_W < MULT_W) begin : g_bad_width
      $error("fraction width too narrow for the shared divider");
   end

   calc_state_e       st_q;
   logic [FREQ_W-1:0] fout_q, fxtal_q, rem_q;
   logic [OD_W-1:0]   odiv_q;
   logic [MULT_W-1:0] mint_q;
   logic              done_q, err_q;
   logic [OD_W-1:0]   out_div_q;
   logic [MULT_W-1:0] mult_q;
   logic [FRAC_W-1:0] frac_q;

   logic              dv_go;
   logic [DVD_W-1:0]  dv_dvd;
   logic [FREQ_W-1:0] dv_dsr;
   logic              dv_valid;
   logic [DVD_W-1:0]  dv_quo;
   logic [FREQ_W-1:0] dv_rem;
   logic              over;
   logic              ratio_ok;
   logic [OD_W-1:0]   even_div;

   fdc_vco_ceiling #(
      .FREQ_W(FREQ_W), .OD_W(OD_W),
      .DEFAULT_DIV(DEFAULT_DIV), .VCO_MAX(VCO_MAX)
   ) u_ceiling (
      .fout (fout_q),
      .over (over)
   );

   fdc_seq_div #(
      .DVD_W(DVD_W), .DSR_W(FREQ_W)
   ) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (dv_go),
      .dividend  (dv_dvd),
      .divisor   (dv_dsr),
      .valid     (dv_valid),
      .quotient  (dv_quo),
      .remainder (dv_rem)
   );

   fdc_ratio_guard #(
      .FREQ_W(FREQ_W), .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX)
   ) u_guard (
      .quo       (dv_quo[FREQ_W-1:0]),
      .quo_hi_nz (|dv_quo[DVD_W-1:FREQ_W]),
      .rem_nz    (|dv_rem),
      .in_range  (ratio_ok)
   );

   // odd quotients lose their lowest bit
   assign even_div = {dv_quo[OD_W-1:1], 1'b0};

   // divider operand selection per stage
   always_comb begin
      dv_go  = 1'b0;
      dv_dvd = '0;
      dv_dsr = fxtal_q;
      case (st_q)
         ST_CHK: begin
            dv_go  = over;
            dv_dvd = DVD_W'(VCO_MAX);
            dv_dsr = fout_q;
         end
         ST_VCO: begin
            dv_go  = 1'b1;
            dv_dvd = DVD_W'(fout_q) * DVD_W'(odiv_q);
         end
         ST_FRAC: begin
            dv_go  = 1'b1;
            dv_dvd = DVD_W'(rem_q) * DVD_W'(FRAC_DEN);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         fout_q    <= '0;
         fxtal_q   <= '0;
         rem_q     <= '0;
         odiv_q    <= '0;
         mint_q    <= '0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         out_div_q <= '0;
         mult_q    <= '0;
         frac_q    <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  fout_q  <= fout;
                  fxtal_q <= fxtal;
                  if (fout == '0) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end else begin
                     st_q <= ST_CHK;
                  end
               end
            end
            ST_CHK: begin
               if (over) begin
                  st_q <= ST_WDIV;
               end else begin
                  odiv_q <= OD_W'(DEFAULT_DIV);
                  st_q   <= ST_VCO;
               end
            end
            ST_WDIV: begin
               if (dv_valid) begin
                  odiv_q <= even_div;
                  st_q   <= ST_VCO;
               end
            end
            ST_VCO: st_q <= ST_WRAT;
            ST_WRAT: begin
               if (dv_valid) begin
                  if (ratio_ok) begin
                     mint_q <= dv_quo[MULT_W-1:0];
                     rem_q  <= dv_rem;
                     st_q   <= ST_FRAC;
                  end else begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                     st_q   <= ST_IDLE;
                  end
               end
            end
            ST_FRAC: st_q <= ST_WNUM;
            ST_WNUM: begin
               if (dv_valid) begin
                  done_q    <= 1'b1;
                  err_q     <= 1'b0;
                  out_div_q <= odiv_q;
                  mult_q    <= mint_q;
                  frac_q    <= dv_quo[FRAC_W-1:0];
                  st_q      <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign done       = done_q;
   assign err        = err_q;
   assign out_div    = out_div_q;
   assign mult_int   = mult_q;
   assign frac_num   = frac_q;
   assign phase_word = out_div_q; // R5: quadrature offset word

   AST_DIV_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !err_q) |-> (out_div_q <= OD_W'(DEFAULT_DIV))); // R1

   AST_DIV_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !err_q) |-> !out_div_q[0]); // R2

   AST_FRAC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !err_q) |-> (frac_q < FRAC_W'(FRAC_DEN))); // R4

   AST_RATIO_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !err_q) |-> ((mult_q >= MULT_W'(RATIO_MIN)) &&
                              (mult_q <= MULT_W'(RATIO_MAX)))); // R6

   AST_HOLD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && err_q) |-> ($stable(out_div_q) && $stable(mult_q) &&
                             $stable(frac_q))); // R7

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R8

   AST_LAST_BIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_WNUM) && dv_valid) |=> (done_q && !err_q)); // R8

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q != ST_IDLE) && start) |=> ($stable(fout_q) && $stable(fxtal_q))); // R9

endmodule

// File: tb/fracn_div_calc_tb.sv
`timescale 1ns/1ps
module fracn_div_calc_tb;

   localparam int NV = 14;
   localparam logic [63:0] VEC [NV] = '{
      {32'd7_000_000,     32'd25_000_000},
      {32'd7_142_857,     32'd25_000_000},
      {32'd7_142_858,     32'd25_000_000},
      {32'd14_000_000,    32'd25_000_000},
      {32'd50_000_000,    32'd25_000_000},
      {32'd1_000_000,     32'd25_000_000},
      {32'd7_000_000,     32'd9_800_000},
      {32'd7_000_000,     32'd9_790_000},
      {32'd7_000_000,     32'd58_800_000},
      {32'd7_000_000,     32'd58_900_000},
      {32'd10_000_000,    32'd27_000_000},
      {32'd0,             32'd25_000_000},
      {32'd1_000_000_000, 32'd25_000_000},
      {32'd7_000_000,     32'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] fout_i = '0;
   logic [31:0] fxtal_i = '0;
   logic        done_o, err_o;
   logic [6:0]  div_o, mult_o, phase_o;
   logic [19:0] frac_o;

   int n_run = 0;
   int n_fail = 0;

   longint unsigned last_div = 0, last_mult = 0, last_frac = 0;

   always #5 clk = ~clk;

   fracn_div_calc u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .fout       (fout_i),
      .fxtal      (fxtal_i),
      .done       (done_o),
      .err        (err_o),
      .out_div    (div_o),
      .mult_int   (mult_o),
      .frac_num   (frac_o),
      .phase_word (phase_o)
   );

   task automatic chk(input string req, input string what,
                      input longint unsigned act, input longint unsigned exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // independent model of the requirements
   task automatic model(input longint unsigned f, input longint unsigned x,
                        output bit ok, output longint unsigned d,
                        output longint unsigned m, output longint unsigned n);
      longint unsigned fv, q, r;
      ok = 1; d = 0; m = 0; n = 0;
      if (f == 0) begin ok = 0; return; end
      d = (f * 126 > 900_000_000) ? (900_000_000 / f) : 126;
      d = d & ~64'd1;
      fv = f * d;
      if (x == 0) begin ok = 0; return; end
      q = fv / x;
      r = fv % x;
      if (q < 15 || q > 90 || (q == 90 && r != 0)) begin ok = 0; return; end
      m = q;
      n = (r * 1_048_575) / x;
   endtask

   // issue one request, wait for done; returns 0 on timeout
   task automatic issue(input logic [31:0] f, input logic [31:0] x, output bit seen);
      int n;
      @(negedge clk);
      start = 1'b1; fout_i = f; fxtal_i = x;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done_o && n < 1000) begin
         @(negedge clk);
         n++;
      end
      seen = done_o;
   endtask

   task automatic check_vec(input logic [31:0] f, input logic [31:0] x);
      bit seen, ok;
      longint unsigned d, m, nm;
      string dtag, etag;
      model(f, x, ok, d, m, nm);
      issue(f, x, seen);
      chk("R8", "done seen", seen, 1);
      etag = (f == 0) ? "R7" : "R6";
      dtag = (longint'(f) * 126 > 900_000_000) ? "R2" : "R1";
      chk(etag, "err flag", err_o, ok ? 0 : 1);
      if (ok) begin
         chk(dtag, "out_div", div_o, d);
         chk("R3", "mult_int", mult_o, m);
         chk("R4", "frac_num", frac_o, nm);
         chk("R5", "phase_word", phase_o, d);
         last_div = d; last_mult = m; last_frac = nm;
      end else begin
         chk(etag, "held out_div", div_o, last_div);
         chk(etag, "held mult_int", mult_o, last_mult);
         chk(etag, "held frac_num", frac_o, last_frac);
      end
      @(negedge clk);
      chk("R8", "done one cycle", done_o, 0);
      chk("R8", "err held after done", err_o, ok ? 0 : 1);
   endtask

   initial begin
      #(150_000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10", "done", done_o, 0);
      chk("R10", "err", err_o, 0);
      chk("R10", "out_div", div_o, 0);
      chk("R10", "mult_int", mult_o, 0);
      chk("R10", "frac_num", frac_o, 0);
      chk("R10", "phase_word", phase_o, 0);

      for (int i = 0; i < NV; i++) begin
         check_vec(VEC[i][63:32], VEC[i][31:0]);
      end

      // R9: a second start during a running request is ignored
      begin
         bit ok;
         longint unsigned d, m, nm;
         int n, extra;
         model(64'd14_000_000, 64'd25_000_000, ok, d, m, nm);
         @(negedge clk);
         start = 1'b1; fout_i = 32'd14_000_000; fxtal_i = 32'd25_000_000;
         @(negedge clk);
         start = 1'b0;
         repeat (10) @(negedge clk);
         start = 1'b1; fout_i = 32'd7_000_000; fxtal_i = 32'd10_000_000;
         @(negedge clk);
         start = 1'b0;
         n = 0;
         while (!done_o && n < 1000) begin
            @(negedge clk);
            n++;
         end
         chk("R9", "done seen", done_o, 1);
         chk("R9", "out_div of first request", div_o, d);
         chk("R9", "mult_int of first request", mult_o, m);
         chk("R9", "frac_num of first request", frac_o, nm);
         extra = 0;
         for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (done_o) extra++;
         end
         chk("R9", "extra done pulses", extra, 0);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule